// File: doc/BRIEF.md
# Multi-Source Clock Mode Controller

This block picks the operating clock for a subsystem from three sources: a high-speed oscillator divided by two, a PLL output, and a low-speed oscillator divided by four or by two. Software writes a small configuration word holding a main-select bit, a sub-select bit, a sub-clock divide bit and a 3-bit PLL multiplier code. A sequencer then performs each mode change under a handover rule that belongs to that change.

Leaving main mode for the PLL waits a fixed settle time, counted in high-speed oscillator edges. Returning from the PLL to main waits until both clocks fall in the same cycle. Entering the sub-clock mode waits for a sub-clock falling edge. The other changes hold the output low, then wait for the new source to go low. The block oversamples the three clock inputs with a fast system clock, so the output clock is a registered signal in that domain. The reported mode changes only when a handover has finished.

Top module: `clkmode_top`

## Requirements
- R1: After reset the mode status is main (code 00), the multiplier output is 000, the sub-clock divide bit selects divide-by-4, and clkOut runs at half the main oscillator rate.
- R2: In main mode (status 00) clkOut has one period for every two main oscillator periods.
- R3: In sub mode (status 10), clkOut is the sub oscillator divided by 4 when cfgSubDiv2 is 0 and divided by 2 when it is 1.
- R4: pllMulOut shows the 3-bit code from the most recent configuration write and changes at no other time.
- R5: A main-to-PLL change (cfgMainSel written 0 while in main mode) completes only after the settle counter has seen 2^SETTLE_LOG2 main oscillator rising edges.
- R6: In PLL mode (status 01) clkOut follows the PLL input at the same period.
- R7: A PLL-to-main change completes in a cycle in which the PLL and the divided main clock both have a falling edge. With coprime periods this happens within 12 PLL periods.
- R8: A change into sub mode completes on a falling edge of the divided sub-clock.
- R9: The status field changes only when a handover completes, never when the request is written.
- R10: A request written while a change is in progress is held. Once the current change completes, the block moves on to the new request.
- R11: clkOut is low in the cycle when the status changes. No high or low phase of clkOut is shorter than the shortest phase of the sources involved.
- R12: A cleared sub-select bit takes priority over the main-select bit. Writing both as 0 from main mode goes straight to sub mode, with no PLL settle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples every source |
| rstN | input | 1 | Active-low synchronous reset |
| mainOscIn | input | 1 | High-speed oscillator input |
| pllClkIn | input | 1 | PLL output clock input |
| subOscIn | input | 1 | Low-speed oscillator input |
| cfgWr | input | 1 | Write strobe for the configuration word |
| cfgMainSel | input | 1 | Main-select bit (1 = main, 0 = PLL) |
| cfgSubSel | input | 1 | Sub-select bit (0 = sub-clock) |
| cfgSubDiv2 | input | 1 | Sub-clock divide bit (1 = /2, 0 = /4) |
| cfgPllMul | input | 3 | PLL multiplier code |
| clkOut | output | 1 | Selected operating clock |
| modeStatus | output | 2 | Completed mode: 00 main, 01 PLL, 10 sub |
| pllMulOut | output | 3 | Multiplier code sent to the PLL |

## Verification
The bench builds the block with SETTLE_LOG2 = 5, so the PLL settle wait is 32 main oscillator edges rather than 16384. This lets the settle window, a request made during the wait, and both PLL exits be checked within a short run. The sources run at periods of 4, 5 and 14 system cycles. Because 5 and 8 are coprime, the edge-coincidence return from the PLL is always reached within eight PLL periods, and phases of two cycles make any one-cycle runt visible.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_SUB  = 2'd2
  } src_e;

  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic outEn;
    src_e sel;
  } ctl_t;
endpackage

// File: rtl/clkmode_dp.sv
module clkmode_dp
  import clkmode_pkg::*;
#(
  parameter int SETTLE_LOG2 = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic mainOscIn,
  input  logic pllClkIn,
  input  logic subOscIn,
  input  logic subDiv2,
  input  ctl_t ctl,
  output logic clkOut,
  output logic mainLvl,
  output logic pllLvl,
  output logic subLvl,
  output logic mainFall,
  output logic pllFall,
  output logic subFall,
  output logic settleDone
);
  localparam int CNT_W = SETTLE_LOG2 + 1;

  logic [1:0] mainS, pllS, subS;
  logic [1:0] subCnt;
  logic       mainPrev, pllPrev, subPrev;
  logic [CNT_W-1:0] settleCnt;
  logic       mainRise, subRise, selLvl;

  assign mainRise = mainS[0] & ~mainS[1];
  assign subRise  = subS[0] & ~subS[1];
  assign pllLvl   = pllS[1];
  assign subLvl   = subDiv2 ? subCnt[0] : subCnt[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainS <= '0; pllS <= '0; subS <= '0;
      mainLvl <= 1'b0; subCnt <= '0;
      mainPrev <= 1'b0; pllPrev <= 1'b0; subPrev <= 1'b0;
    end else begin
      mainS <= {mainS[0], mainOscIn};
      pllS  <= {pllS[0], pllClkIn};
      subS  <= {subS[0], subOscIn};
      if (mainRise) mainLvl <= ~mainLvl;
      if (subRise)  subCnt  <= subCnt + 2'd1;
      mainPrev <= mainLvl;
      pllPrev  <= pllLvl;
      subPrev  <= subLvl;
    end
  end

  assign mainFall = mainPrev & ~mainLvl;
  assign pllFall  = pllPrev & ~pllLvl;
  assign subFall  = subPrev & ~subLvl;

  // settle counter saturates at its top bit and holds until cleared
  assign settleDone = settleCnt[CNT_W-1];
  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) settleCnt <= '0;
    else if (ctl.cntEn && mainRise && !settleDone) settleCnt <= settleCnt + 1'b1;
  end

  always_comb begin
    case (ctl.sel)
      SRC_PLL: selLvl = pllLvl;
      SRC_SUB: selLvl = subLvl;
      default: selLvl = mainLvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) clkOut <= 1'b0;
    else       clkOut <= ctl.outEn & selLvl;
  end
endmodule

// File: rtl/clkmode_ctl.sv
module clkmode_ctl
  import clkmode_pkg::*;
#(
  parameter int MUL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgMainSel,
  input  logic             cfgSubSel,
  input  logic             cfgSubDiv2,
  input  logic [MUL_W-1:0] cfgPllMul,
  input  logic             mainLvl,
  input  logic             pllLvl,
  input  logic             subLvl,
  input  logic             mainFall,
  input  logic             pllFall,
  input  logic             subFall,
  input  logic             settleDone,
  output ctl_t             ctl,
  output logic [1:0]       modeStatus,
  output logic [MUL_W-1:0] pllMulOut,
  output logic             subDiv2
);
  typedef enum logic [2:0] {ST_RUN, ST_SETTLE, ST_COIN, ST_GATE, ST_WAITNEW} st_e;

  st_e  state;
  src_e curSrc, tgtSrc, reqSrc;
  logic mainSel, subSel;
  logic oldLvl, newLvl, newReady;

  function automatic logic pickLvl(src_e s, logic m, logic p, logic b);
    case (s)
      SRC_PLL: return p;
      SRC_SUB: return b;
      default: return m;
    endcase
  endfunction

  // sub-select outranks main-select
  always_comb begin
    if (!subSel)       reqSrc = SRC_SUB;
    else if (!mainSel) reqSrc = SRC_PLL;
    else               reqSrc = SRC_MAIN;
  end

  assign oldLvl   = pickLvl(curSrc, mainLvl, pllLvl, subLvl);
  assign newLvl   = pickLvl(tgtSrc, mainLvl, pllLvl, subLvl);
  assign newReady = (tgtSrc == SRC_SUB) ? subFall : !newLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainSel <= 1'b1; subSel <= 1'b1; subDiv2 <= 1'b0; pllMulOut <= '0;
    end else if (cfgWr) begin
      mainSel <= cfgMainSel; subSel <= cfgSubSel;
      subDiv2 <= cfgSubDiv2; pllMulOut <= cfgPllMul;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN; curSrc <= SRC_MAIN; tgtSrc <= SRC_MAIN;
    end else begin
      case (state)
        ST_RUN: if (reqSrc != curSrc) begin
          tgtSrc <= reqSrc;
          if (curSrc == SRC_MAIN && reqSrc == SRC_PLL)      state <= ST_SETTLE;
          else if (curSrc == SRC_PLL && reqSrc == SRC_MAIN) state <= ST_COIN;
          else                                              state <= ST_GATE;
        end
        ST_SETTLE: if (settleDone) state <= ST_GATE;
        ST_COIN: if (pllFall && mainFall) begin
          curSrc <= SRC_MAIN;
          state  <= ST_RUN;
        end
        ST_GATE: if (!oldLvl) state <= ST_WAITNEW;
        ST_WAITNEW: if (newReady) begin
          curSrc <= tgtSrc;
          state  <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    ctl.cntClr = (state == ST_RUN);
    ctl.cntEn  = (state == ST_SETTLE);
    ctl.outEn  = (state != ST_WAITNEW);
    ctl.sel    = curSrc;
  end

  assign modeStatus = curSrc;
endmodule

// File: rtl/clkmode_top.sv
module clkmode_top
  import clkmode_pkg::*;
#(
  parameter int SETTLE_LOG2 = 14,
  parameter int MUL_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mainOscIn,
  input  logic             pllClkIn,
  input  logic             subOscIn,
  input  logic             cfgWr,
  input  logic             cfgMainSel,
  input  logic             cfgSubSel,
  input  logic             cfgSubDiv2,
  input  logic [MUL_W-1:0] cfgPllMul,
  output logic             clkOut,
  output logic [1:0]       modeStatus,
  output logic [MUL_W-1:0] pllMulOut
);
  ctl_t ctl;
  logic mainLvl, pllLvl, subLvl, mainFall, pllFall, subFall, settleDone, subDiv2;

  clkmode_ctl #(.MUL_W(MUL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMainSel(cfgMainSel),
    .cfgSubSel(cfgSubSel), .cfgSubDiv2(cfgSubDiv2), .cfgPllMul(cfgPllMul),
    .mainLvl(mainLvl), .pllLvl(pllLvl), .subLvl(subLvl),
    .mainFall(mainFall), .pllFall(pllFall), .subFall(subFall),
    .settleDone(settleDone), .ctl(ctl), .modeStatus(modeStatus),
    .pllMulOut(pllMulOut), .subDiv2(subDiv2)
  );

  clkmode_dp #(.SETTLE_LOG2(SETTLE_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .mainOscIn(mainOscIn), .pllClkIn(pllClkIn),
    .subOscIn(subOscIn), .subDiv2(subDiv2), .ctl(ctl), .clkOut(clkOut),
    .mainLvl(mainLvl), .pllLvl(pllLvl), .subLvl(subLvl),
    .mainFall(mainFall), .pllFall(pllFall), .subFall(subFall),
    .settleDone(settleDone)
  );
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk #(
  parameter int MUL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWr,
  input logic [1:0]       modeStatus,
  input logic [MUL_W-1:0] pllMulOut,
  input logic             clkOut,
  input logic             settleDone,
  input logic             pllFall,
  input logic             mainFall,
  input logic             subFall
);
  // R1: status takes only the three legal codes
  a_r1_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    modeStatus != 2'b11);

  // R4: multiplier code moves only after a write
  a_r4_mul_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWr) |-> $stable(pllMulOut));

  // R5: main-to-PLL handover follows a finished settle count
  a_r5_settle_first: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b01 && $past(modeStatus) == 2'b00) |-> $past(settleDone));

  // R7: PLL-to-main handover on coinciding falls
  a_r7_coincide: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b00 && $past(modeStatus) == 2'b01) |-> $past(pllFall && mainFall));

  // R8: entry to sub mode on a sub-clock fall
  a_r8_sub_sync: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b10 && $past(modeStatus) != 2'b10) |-> $past(subFall));

  // R11: output is low when the status changes
  a_r11_low_at_switch: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus != $past(modeStatus)) |-> !clkOut);
endmodule

bind clkmode_top clkmode_chk #(.MUL_W(MUL_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .modeStatus(modeStatus),
  .pllMulOut(pllMulOut), .clkOut(clkOut), .settleDone(settleDone),
  .pllFall(pllFall), .mainFall(mainFall), .subFall(subFall)
);

// File: tb/sim_clkmode_top.sv
`timescale 1ns/1ps
module sim_clkmode_top;
  localparam int SL = 5;
  localparam int SETTLE_EDGES = 1 << SL;
  localparam int P_MAIN = 4, P_PLL = 5, P_SUB = 14;

  logic clk = 1'b0, rstN = 1'b0;
  logic mainOscIn = 1'b0, pllClkIn = 1'b0, subOscIn = 1'b0;
  logic cfgWr = 1'b0, cfgMainSel = 1'b1, cfgSubSel = 1'b1, cfgSubDiv2 = 1'b0;
  logic [2:0] cfgPllMul = 3'd0;
  logic clkOut;
  logic [1:0] modeStatus;
  logic [2:0] pllMulOut;

  int nChecks = 0, nFails = 0, cyc = 0;
  int runLen = 0, runts = 0;
  logic lastOut = 1'b0;
  logic [2:0] curMul = 3'd0;

  clkmode_top #(.SETTLE_LOG2(SL)) u0 (
    .clk(clk), .rstN(rstN), .mainOscIn(mainOscIn), .pllClkIn(pllClkIn),
    .subOscIn(subOscIn), .cfgWr(cfgWr), .cfgMainSel(cfgMainSel),
    .cfgSubSel(cfgSubSel), .cfgSubDiv2(cfgSubDiv2), .cfgPllMul(cfgPllMul),
    .clkOut(clkOut), .modeStatus(modeStatus), .pllMulOut(pllMulOut)
  );

  always #4 clk = ~clk;

  // source waveforms, driven just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    mainOscIn = (cyc % P_MAIN) < (P_MAIN / 2);
    pllClkIn  = (cyc % P_PLL) < 2;
    subOscIn  = (cyc % P_SUB) < (P_SUB / 2);
  end

  // R11 runt monitor: every phase at least 2 system cycles
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      if (clkOut != lastOut) begin
        if (runLen < 2 && runLen > 0) runts++;
        runLen = 1;
      end else runLen++;
      lastOut = clkOut;
    end
  end

  function automatic int expPeriod(int mode, bit div2);
    case (mode)
      1: return P_PLL;
      2: return div2 ? 2 * P_SUB : 4 * P_SUB;
      default: return 2 * P_MAIN;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(bit m, bit s, bit d, logic [2:0] mul);
    @(negedge clk);
    cfgMainSel = m; cfgSubSel = s; cfgSubDiv2 = d; cfgPllMul = mul; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
    curMul = mul;
  endtask

  task automatic waitMode(logic [1:0] m, int lim, output int took);
    took = 0;
    while (modeStatus != m && took < lim) begin
      @(negedge clk);
      took++;
    end
  endtask

  task automatic measure(output int per);
    int t = 0;
    while (clkOut) begin @(negedge clk); t++; end
    while (!clkOut && t < 400) begin @(negedge clk); t++; end
    per = 0;
    for (int k = 0; k < 4; k++) begin
      do begin @(negedge clk); per++; end while (clkOut && per < 1000);
      do begin @(negedge clk); per++; end while (!clkOut && per < 1000);
    end
    per = per / 4;
  endtask

  initial begin
    int per, took;
    bit sawPll;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(modeStatus == 2'b00, "R1 status", modeStatus, 0);
    check(pllMulOut == 3'd0, "R1 mul", pllMulOut, 0);
    measure(per);
    check(per == expPeriod(0, 0), "R1 R2 main period", per, expPeriod(0, 0));

    // R4 random multiplier writes, R9 status unaffected
    for (int i = 0; i < 16; i++) begin
      logic [2:0] mul = 3'($urandom_range(7));
      writeCfg(1'b1, 1'b1, 1'b0, mul);
      repeat ($urandom_range(1, 4)) @(negedge clk);
      check(pllMulOut == mul, "R4 mul echo", pllMulOut, mul);
    end
    check(modeStatus == 2'b00, "R9 status steady", modeStatus, 0);

    // R5 main to PLL, R9 status held during settle
    writeCfg(1'b0, 1'b1, 1'b0, curMul);
    repeat (20) @(negedge clk);
    check(modeStatus == 2'b00, "R9 status before handover", modeStatus, 0);
    waitMode(2'b01, 400, took);
    took += 21;
    check(took >= SETTLE_EDGES * P_MAIN - 8 && took <= SETTLE_EDGES * P_MAIN + 24,
          "R5 settle latency", took, SETTLE_EDGES * P_MAIN);
    measure(per);
    check(per == P_PLL, "R6 pll period", per, P_PLL);

    // R7 PLL back to main
    writeCfg(1'b1, 1'b1, 1'b0, curMul);
    waitMode(2'b00, 400, took);
    check(modeStatus == 2'b00 && took <= 12 * P_PLL + 4, "R7 return latency", took, 12 * P_PLL);
    measure(per);
    check(per == expPeriod(0, 0), "R2 main period after PLL", per, expPeriod(0, 0));

    // R8 main to sub /4, R3
    writeCfg(1'b1, 1'b0, 1'b0, curMul);
    waitMode(2'b10, 400, took);
    check(modeStatus == 2'b10 && took <= 4 * P_SUB + 12, "R8 sub entry", took, 4 * P_SUB);
    measure(per);
    check(per == expPeriod(2, 0), "R3 sub div4 period", per, expPeriod(2, 0));

    // back to main, select /2, re-enter sub
    writeCfg(1'b1, 1'b1, 1'b1, curMul);
    waitMode(2'b00, 400, took);
    check(modeStatus == 2'b00, "R2 sub to main", modeStatus, 0);
    writeCfg(1'b1, 1'b0, 1'b1, curMul);
    waitMode(2'b10, 400, took);
    measure(per);
    check(per == expPeriod(2, 1), "R3 sub div2 period", per, expPeriod(2, 1));
    writeCfg(1'b1, 1'b1, 1'b0, curMul);
    waitMode(2'b00, 400, took);

    // R10 request made during the settle wait
    writeCfg(1'b0, 1'b1, 1'b0, curMul);
    repeat (30) @(negedge clk);
    writeCfg(1'b1, 1'b1, 1'b0, curMul);
    waitMode(2'b01, 400, took);
    check(modeStatus == 2'b01, "R10 pending: PLL reached first", modeStatus, 1);
    waitMode(2'b00, 400, took);
    check(modeStatus == 2'b00, "R10 pending: main restored", modeStatus, 0);

    // R12 sub-select outranks main-select
    sawPll = 1'b0;
    writeCfg(1'b0, 1'b0, 1'b0, curMul);
    took = 0;
    while (modeStatus != 2'b10 && took < 400) begin
      @(negedge clk); took++;
      if (modeStatus == 2'b01) sawPll = 1'b1;
    end
    check(modeStatus == 2'b10 && !sawPll, "R12 direct to sub", modeStatus, 2);
    check(took < SETTLE_EDGES * P_MAIN, "R12 no settle wait", took, SETTLE_EDGES * P_MAIN);

    check(runts == 0, "R11 runt phases", runts, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule